// File: doc/BRIEF.md
# Packed SIMD Lane Accumulator

This block is a 64-bit packed arithmetic unit with a file of wide per-lane accumulators. In byte format the 64-bit vectors hold eight unsigned 8-bit elements, and each element has a 24-bit signed accumulator. In halfword format they hold four signed 16-bit elements, and each has a 48-bit accumulator. Lane 0 always takes the least significant bits of a vector. One command may update every lane accumulator at once. The command can add, multiply, subtract, take a negated product or take a byte absolute difference. Each of these comes in a form that adds into the accumulator and a form that loads it.

The second operand of an arithmetic command comes from one of three places: the whole second vector taken lane by lane, one element of that vector copied to every lane, or an immediate copied to every lane. The same command port can also write the low part or the top field of every accumulator, or read an element-wide slice of every accumulator into a registered result. An illegal request raises a one-cycle error flag and changes nothing.

Top module: `simd_lane_acc`

## Requirements
- R1: While `rst` is high, and after it, the accumulator file is zero and `rd_data` and `err` are 0.
- R2: In byte format (`fmt`=0), with `cmd`=0 and `cmd_valid` high, each lane acts on unsigned bytes `a` (from `vec_a`) and `b`. The opcodes are: 0 acc+=a+b, 1 acc=a+b, 2 acc+=a*b, 3 acc=a*b, 4 acc-=a*b, 5 acc=-(a*b), 6 acc+=a-b, 7 acc=a-b. Results wrap modulo 2^24. Byte lane i uses `vec_a[8i+7:8i]`.
- R3: In halfword format (`fmt`=1), the same opcodes 0 to 7 act on signed 16-bit elements, and results wrap modulo 2^48. Halfword lane j uses `vec_a[16j+15:16j]`.
- R4: Opcode 8 in byte format adds the unsigned magnitude |a-b| to each lane accumulator.
- R5: `src_mode` picks `b`. 0 takes lane i of `vec_b`. 1 takes element `elem_idx` of `vec_b` (byte format), or element `elem_idx` mod 4 (halfword format), and copies it to all lanes. 2 takes `imm[7:0]` (byte format) or the signed `imm[15:0]` (halfword format) and copies it to all lanes.
- R6: `cmd`=3 loads `rd_data` on the next clock. Each lane puts the element-wide field that starts at bit `rd_sel`*8 (byte format) or `rd_sel`*16 (halfword format) of its accumulator into its own element position. The accumulators do not change.
- R7: `cmd`=1 sets each accumulator to the sign-extended `vec_a` element above the matching `vec_b` element. That is bits 23:8 and 7:0 in byte format, and bits 47:16 and 15:0 in halfword format.
- R8: `cmd`=2 replaces only the top element-wide field of each accumulator (bits 23:16 or 47:32) with the matching `vec_a` element. All lower bits keep their value.
- R9: Any of these requests sets `err` for the next cycle and leaves both the accumulators and `rd_data` unchanged: `fmt` of 2 or 3; opcode above 8; opcode 8 in halfword format; `src_mode`=3 on an arithmetic command; `rd_sel`=3 on a read. Every other cycle has `err` low.
- R10: With `cmd_valid` low, nothing changes. A command other than a read leaves `rd_data` unchanged.
- R11: Both formats share one 192-bit accumulator file. Byte lane i is bits 24i+23:24i and halfword lane j is bits 48j+47:48j, so halfword lane j overlays byte lanes 2j and 2j+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe; the request commits on this clock edge |
| cmd | input | 2 | 0 arithmetic, 1 low write, 2 top-field write, 3 slice read |
| fmt | input | 2 | 0 byte format, 1 halfword format, 2 and 3 illegal |
| opcode | input | 4 | Arithmetic opcode 0 to 8 |
| src_mode | input | 2 | Second-operand source: 0 vector, 1 element, 2 immediate |
| elem_idx | input | 3 | Element index for the element mode |
| imm | input | 16 | Immediate operand |
| rd_sel | input | 2 | Slice select for reads: 0 low, 1 middle, 2 high |
| vec_a | input | 64 | First vector |
| vec_b | input | 64 | Second vector |
| rd_data | output | 64 | Registered slice read result |
| err | output | 1 | Registered flag for an illegal request |

## Verification
The assertions assume that `rst` is applied at start-up and that every input is a known value at each clock edge. They need no other promise about the input encodings, because illegal formats, opcodes, source modes and slice selects are part of the defined behaviour (R9). To exercise those paths, the random stimulus mixes in requests with illegal fields and idle cycles. It also changes format between commands, so that one format reads data written in the other through the shared storage.

// File: rtl/simd_acc_pkg.sv
package simd_acc_pkg;
  typedef enum logic [1:0] {
    CMD_ARITH = 2'd0,
    CMD_WLO   = 2'd1,
    CMD_WHI   = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  localparam logic [1:0] FMT_BYTE = 2'd0;
  localparam logic [1:0] FMT_HALF = 2'd1;

  localparam logic [1:0] SRC_VEC  = 2'd0;
  localparam logic [1:0] SRC_ELEM = 2'd1;
  localparam logic [1:0] SRC_IMM  = 2'd2;

  localparam logic [3:0] OP_ADD_ACC = 4'd0;
  localparam logic [3:0] OP_ADD_LD  = 4'd1;
  localparam logic [3:0] OP_MUL_ACC = 4'd2;
  localparam logic [3:0] OP_MUL_LD  = 4'd3;
  localparam logic [3:0] OP_MUL_SUB = 4'd4;
  localparam logic [3:0] OP_NMUL_LD = 4'd5;
  localparam logic [3:0] OP_SUB_ACC = 4'd6;
  localparam logic [3:0] OP_SUB_LD  = 4'd7;
  localparam logic [3:0] OP_ABSD    = 4'd8;
endpackage

// File: rtl/simd_acc_lane.sv
module simd_acc_lane #(
  parameter int EW        = 8,
  parameter int AW        = 24,
  parameter bit SIGNED_EL = 1'b0
) (
  input  logic [3:0]    op,
  input  logic [AW-1:0] acc_in,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [AW-1:0] acc_out
);
  import simd_acc_pkg::*;

  localparam int XW = AW - EW;

  logic [AW-1:0] ea, eb, prod, absd;
  logic [EW-1:0] mag;

  always_comb begin
    ea   = {{XW{SIGNED_EL & a[EW-1]}}, a};
    eb   = {{XW{SIGNED_EL & b[EW-1]}}, b};
    prod = ea * eb;
    mag  = (a >= b) ? (a - b) : (b - a);
    absd = {{XW{1'b0}}, mag};
    case (op)
      OP_ADD_ACC: acc_out = acc_in + ea + eb;
      OP_ADD_LD:  acc_out = ea + eb;
      OP_MUL_ACC: acc_out = acc_in + prod;
      OP_MUL_LD:  acc_out = prod;
      OP_MUL_SUB: acc_out = acc_in - prod;
      OP_NMUL_LD: acc_out = -prod;
      OP_SUB_ACC: acc_out = acc_in + ea - eb;
      OP_SUB_LD:  acc_out = ea - eb;
      OP_ABSD:    acc_out = acc_in + absd;
      default:    acc_out = acc_in;
    endcase
  end
endmodule

// File: rtl/simd_acc_operand.sv
module simd_acc_operand #(
  parameter int DATA_W = 64,
  parameter int EW     = 8
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        idx,
  input  logic [EW-1:0]     imm,
  input  logic [DATA_W-1:0] vec_b,
  output logic [DATA_W-1:0] b_eff
);
  import simd_acc_pkg::*;

  localparam int N = DATA_W / EW;

  logic [EW-1:0] pick;

  always_comb begin
    pick = vec_b[(int'(idx) % N) * EW +: EW];
    for (int i = 0; i < N; i++) begin
      case (mode)
        SRC_ELEM: b_eff[i*EW +: EW] = pick;
        SRC_IMM:  b_eff[i*EW +: EW] = imm;
        default:  b_eff[i*EW +: EW] = vec_b[i*EW +: EW];
      endcase
    end
  end
endmodule

// File: rtl/simd_lane_acc.sv
module simd_lane_acc #(
  parameter int DATA_W  = 64,
  parameter int BYTE_W  = 8,
  parameter int HALF_W  = 16,
  parameter int ACC_MUL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd,
  input  logic [1:0]        fmt,
  input  logic [3:0]        opcode,
  input  logic [1:0]        src_mode,
  input  logic [2:0]        elem_idx,
  input  logic [HALF_W-1:0] imm,
  input  logic [1:0]        rd_sel,
  input  logic [DATA_W-1:0] vec_a,
  input  logic [DATA_W-1:0] vec_b,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);
  import simd_acc_pkg::*;

  localparam int NB     = DATA_W / BYTE_W;
  localparam int NH     = DATA_W / HALF_W;
  localparam int BAW    = BYTE_W * ACC_MUL;
  localparam int HAW    = HALF_W * ACC_MUL;
  localparam int FILE_W = NB * BAW;

  cmd_e              c;
  logic [FILE_W-1:0] acc_q, acc_next;
  logic [FILE_W-1:0] ar_byte, ar_half, wlo_byte, wlo_half, whi_byte, whi_half;
  logic [DATA_W-1:0] bvec_byte, bvec_half, rd_byte, rd_half;
  logic [1:0]        sel_c;
  logic              fmt_bad, arith_bad, rd_bad, bad;

  assign c     = cmd_e'(cmd);
  assign sel_c = (rd_sel == 2'd3) ? 2'd0 : rd_sel;

  assign fmt_bad   = (fmt != FMT_BYTE) && (fmt != FMT_HALF);
  assign arith_bad = (c == CMD_ARITH) &&
                     ((opcode > OP_ABSD) || (src_mode == 2'd3) ||
                      ((opcode == OP_ABSD) && (fmt == FMT_HALF)));
  assign rd_bad    = (c == CMD_READ) && (rd_sel == 2'd3);
  assign bad       = fmt_bad | arith_bad | rd_bad;

  simd_acc_operand #(.DATA_W(DATA_W), .EW(BYTE_W)) u_opb (
    .mode(src_mode), .idx(elem_idx), .imm(imm[BYTE_W-1:0]),
    .vec_b(vec_b), .b_eff(bvec_byte)
  );
  simd_acc_operand #(.DATA_W(DATA_W), .EW(HALF_W)) u_oph (
    .mode(src_mode), .idx(elem_idx), .imm(imm),
    .vec_b(vec_b), .b_eff(bvec_half)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_acc_lane #(.EW(BYTE_W), .AW(BAW), .SIGNED_EL(1'b0)) u_lane (
      .op(opcode), .acc_in(acc_q[i*BAW +: BAW]),
      .a(vec_a[i*BYTE_W +: BYTE_W]), .b(bvec_byte[i*BYTE_W +: BYTE_W]),
      .acc_out(ar_byte[i*BAW +: BAW])
    );
    assign wlo_byte[i*BAW +: BAW] = {{(BAW-2*BYTE_W){vec_a[i*BYTE_W+BYTE_W-1]}},
                                     vec_a[i*BYTE_W +: BYTE_W], vec_b[i*BYTE_W +: BYTE_W]};
    assign whi_byte[i*BAW +: BAW] = {vec_a[i*BYTE_W +: BYTE_W], acc_q[i*BAW +: BAW-BYTE_W]};
    assign rd_byte[i*BYTE_W +: BYTE_W] = acc_q[i*BAW + int'(sel_c)*BYTE_W +: BYTE_W];
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    simd_acc_lane #(.EW(HALF_W), .AW(HAW), .SIGNED_EL(1'b1)) u_lane (
      .op(opcode), .acc_in(acc_q[j*HAW +: HAW]),
      .a(vec_a[j*HALF_W +: HALF_W]), .b(bvec_half[j*HALF_W +: HALF_W]),
      .acc_out(ar_half[j*HAW +: HAW])
    );
    assign wlo_half[j*HAW +: HAW] = {{(HAW-2*HALF_W){vec_a[j*HALF_W+HALF_W-1]}},
                                     vec_a[j*HALF_W +: HALF_W], vec_b[j*HALF_W +: HALF_W]};
    assign whi_half[j*HAW +: HAW] = {vec_a[j*HALF_W +: HALF_W], acc_q[j*HAW +: HAW-HALF_W]};
    assign rd_half[j*HALF_W +: HALF_W] = acc_q[j*HAW + int'(sel_c)*HALF_W +: HALF_W];
  end

  always_comb begin
    case (c)
      CMD_ARITH: acc_next = (fmt == FMT_HALF) ? ar_half  : ar_byte;
      CMD_WLO:   acc_next = (fmt == FMT_HALF) ? wlo_half : wlo_byte;
      CMD_WHI:   acc_next = (fmt == FMT_HALF) ? whi_half : whi_byte;
      default:   acc_next = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      rd_data <= '0;
      err     <= 1'b0;
    end else begin
      err <= cmd_valid & bad;
      if (cmd_valid && !bad) begin
        if (c == CMD_READ) rd_data <= (fmt == FMT_HALF) ? rd_half : rd_byte;
        else               acc_q   <= acc_next;
      end
    end
  end

  // R10: idle cycles change nothing and raise no error
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(acc_q) && $stable(rd_data) && !err));

  // R6: a slice read never disturbs the accumulators
  assert_read_keeps_acc_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c == CMD_READ) |=> $stable(acc_q));

  // R10: non-read commands keep the read result
  assert_write_keeps_rd_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c != CMD_READ) |=> $stable(rd_data));

  // R9: rejected requests flag an error and leave state alone
  assert_bad_no_update_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && bad) |=> (err && $stable(acc_q) && $stable(rd_data)));

  // R8: halfword top-field write keeps the lower bits of lane 0
  assert_hi_keeps_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c == CMD_WHI && fmt == FMT_HALF) |=>
      (acc_q[HAW-HALF_W-1:0] == $past(acc_q[HAW-HALF_W-1:0])));
endmodule

// File: tb/tb_simd_lane_acc.sv
module tb_simd_lane_acc;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [1:0]  cmd, fmt, src_mode, rd_sel;
  logic [3:0]  opcode;
  logic [2:0]  elem_idx;
  logic [15:0] imm;
  logic [63:0] vec_a, vec_b;
  logic [63:0] rd_data;
  logic        err;

  logic [191:0] mdl;
  logic [63:0]  exp_rd;
  logic         exp_err;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  simd_lane_acc dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .fmt(fmt),
    .opcode(opcode), .src_mode(src_mode), .elem_idx(elem_idx), .imm(imm),
    .rd_sel(rd_sel), .vec_a(vec_a), .vec_b(vec_b), .rd_data(rd_data), .err(err)
  );

  function automatic longint opcalc(input int op, input longint acc,
                                    input longint a, input longint b);
    case (op)
      0: return acc + a + b;
      1: return a + b;
      2: return acc + a * b;
      3: return a * b;
      4: return acc - a * b;
      5: return -(a * b);
      6: return acc + a - b;
      7: return a - b;
      default: return acc + ((a >= b) ? a - b : b - a);
    endcase
  endfunction

  task automatic model();
    bit illegal;
    longint acc, a, b, r;
    illegal = (fmt > 2'd1) ||
              (cmd == 2'd0 && (opcode > 4'd8 || src_mode == 2'd3 ||
                               (opcode == 4'd8 && fmt == 2'd1))) ||
              (cmd == 2'd3 && rd_sel == 2'd3);
    exp_err = cmd_valid && illegal;
    if (!cmd_valid || illegal) return;
    if (fmt == 2'd0) begin
      for (int i = 0; i < 8; i++) begin
        a = longint'(vec_a[8*i +: 8]);
        case (src_mode)
          2'd0: b = longint'(vec_b[8*i +: 8]);
          2'd1: b = longint'(vec_b[8*int'(elem_idx) +: 8]);
          default: b = longint'(imm[7:0]);
        endcase
        acc = longint'(mdl[24*i +: 24]);
        case (cmd)
          2'd0: begin r = opcalc(int'(opcode), acc, a, b); mdl[24*i +: 24] = r[23:0]; end
          2'd1: mdl[24*i +: 24] = {{8{vec_a[8*i+7]}}, vec_a[8*i +: 8], vec_b[8*i +: 8]};
          2'd2: mdl[24*i+16 +: 8] = vec_a[8*i +: 8];
          default: exp_rd[8*i +: 8] = mdl[24*i + 8*int'(rd_sel) +: 8];
        endcase
      end
    end else begin
      for (int j = 0; j < 4; j++) begin
        a = longint'($signed(vec_a[16*j +: 16]));
        case (src_mode)
          2'd0: b = longint'($signed(vec_b[16*j +: 16]));
          2'd1: b = longint'($signed(vec_b[16*(int'(elem_idx) % 4) +: 16]));
          default: b = longint'($signed(imm));
        endcase
        acc = longint'(mdl[48*j +: 48]);
        case (cmd)
          2'd0: begin r = opcalc(int'(opcode), acc, a, b); mdl[48*j +: 48] = r[47:0]; end
          2'd1: mdl[48*j +: 48] = {{16{vec_a[16*j+15]}}, vec_a[16*j +: 16], vec_b[16*j +: 16]};
          2'd2: mdl[48*j+32 +: 16] = vec_a[16*j +: 16];
          default: exp_rd[16*j +: 16] = mdl[48*j + 16*int'(rd_sel) +: 16];
        endcase
      end
    end
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk);
    #1;
    checks++;
    if (rd_data !== exp_rd || err !== exp_err) begin
      errors++;
      $display("FAIL %s: rd_data=%h err=%b expected rd_data=%h err=%b",
               tag, rd_data, err, exp_rd, exp_err);
    end
  endtask

  task automatic expect_rd(input string tag, input logic [63:0] val);
    checks++;
    if (rd_data !== val) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, val);
    end
  endtask

  task automatic req(input logic v, input logic [1:0] c, input logic [1:0] f,
                     input logic [3:0] op, input logic [1:0] m, input logic [2:0] ix,
                     input logic [15:0] im, input logic [1:0] rs,
                     input logic [63:0] a, input logic [63:0] b);
    cmd_valid = v; cmd = c; fmt = f; opcode = op; src_mode = m;
    elem_idx = ix; imm = im; rd_sel = rs; vec_a = a; vec_b = b;
  endtask

  task automatic rd(input string tag, input logic [1:0] f, input logic [1:0] s);
    req(1, 3, f, 0, 0, 0, 0, s, 64'h0, 64'h0);
    step(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mdl = '0; exp_rd = '0; exp_err = 1'b0;
    rst = 1'b1;
    req(0, 0, 0, 0, 0, 0, 0, 0, 64'h0, 64'h0);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rd_data !== 64'h0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R1: rd_data=%h err=%b expected 0 0", rd_data, err);
    end
    rst = 1'b0;
    rd("R1 reset low slice", 0, 0);
    rd("R1 reset high slice", 1, 2);
    expect_rd("R1 zero file", 64'h0);

    // R7: low write, sign extension into the top field
    req(1, 1, 0, 0, 0, 0, 0, 0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0011);
    step("R7 low write byte");
    rd("R7 read high", 0, 2);
    expect_rd("R7 sign ext", 64'h0000_0000_0000_00FF);
    rd("R7 read low", 0, 0);
    expect_rd("R7 low field", 64'h0000_0000_0000_0011);

    // R8: top-field write keeps lower bits
    req(1, 1, 0, 0, 0, 0, 0, 0, 64'h0, 64'h1111_1111_1111_1111);
    step("R8 setup");
    req(1, 2, 0, 0, 0, 0, 0, 0, 64'hABAB_ABAB_ABAB_ABAB, 64'h0);
    step("R8 high write byte");
    rd("R8 read high", 0, 2);
    expect_rd("R8 top field", 64'hABAB_ABAB_ABAB_ABAB);
    rd("R8 read low", 0, 0);
    expect_rd("R8 low kept", 64'h1111_1111_1111_1111);
    req(1, 2, 1, 0, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'h0);
    step("R8 high write half");
    rd("R8 half low kept", 1, 0);

    // R2: byte wrap
    req(1, 1, 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R2 setup");
    req(1, 0, 0, 0, 0, 0, 0, 0, 64'h0101_0101_0101_0101, 64'h0);
    step("R2 add wraps");
    rd("R2 read high", 0, 2);
    expect_rd("R2 wrap to zero", 64'h0);
    for (int op = 0; op < 8; op++) begin
      req(1, 0, 0, op[3:0], 0, 0, 0, 0, 64'hF00F_8040_2010_0302, 64'h0FF0_7F80_FF01_0203);
      step("R2 byte opcodes");
      rd("R2 byte readback", 0, int'(op % 3));
    end

    // R3: signed halfword multiply
    req(1, 1, 1, 0, 0, 0, 0, 0, 64'h0, 64'h0);
    step("R3 clear");
    req(1, 0, 1, 2, 0, 0, 0, 0, 64'hFFFD_FFFD_FFFD_FFFD, 64'h0005_0005_0005_0005);
    step("R3 mul acc");
    rd("R3 read low", 1, 0);
    expect_rd("R3 signed product", 64'hFFF1_FFF1_FFF1_FFF1);
    rd("R3 read high", 1, 2);
    expect_rd("R3 sign in top", 64'hFFFF_FFFF_FFFF_FFFF);
    for (int op = 0; op < 8; op++) begin
      req(1, 0, 1, op[3:0], 0, 0, 0, 0, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0002_FFFE);
      step("R3 half opcodes");
      rd("R3 half readback", 1, int'(op % 3));
    end

    // R4: absolute difference
    req(1, 1, 0, 0, 0, 0, 0, 0, 64'h0, 64'h0);
    step("R4 clear");
    req(1, 0, 0, 8, 0, 0, 0, 0, 64'h1010_1010_1010_1010, 64'h3030_3030_3030_3030);
    step("R4 absd 1");
    req(1, 0, 0, 8, 0, 0, 0, 0, 64'h3030_3030_3030_3030, 64'h1010_1010_1010_1010);
    step("R4 absd 2");
    rd("R4 read", 0, 0);
    expect_rd("R4 sum of magnitudes", 64'h4040_4040_4040_4040);

    // R5: element and immediate broadcast
    req(1, 0, 0, 1, 1, 3, 0, 0, 64'h0, 64'h0000_0000_2100_0000);
    step("R5 element byte");
    rd("R5 read", 0, 0);
    expect_rd("R5 element broadcast", 64'h2121_2121_2121_2121);
    req(1, 0, 0, 1, 2, 0, 16'hAA05, 0, 64'h0, 64'hFFFF);
    step("R5 imm byte");
    rd("R5 read imm", 0, 0);
    expect_rd("R5 imm broadcast", 64'h0505_0505_0505_0505);
    req(1, 0, 1, 3, 1, 6, 0, 0, 64'h0002_0002_0002_0002, 64'h0000_FFFF_0000_0000);
    step("R5 element half idx mod 4");
    rd("R5 half read", 1, 0);
    expect_rd("R5 half element", 64'hFFFE_FFFE_FFFE_FFFE);
    req(1, 0, 1, 1, 2, 0, 16'hFFFF, 0, 64'h0, 64'h0);
    step("R5 imm half");
    rd("R5 half imm read", 1, 2);
    expect_rd("R5 imm sign", 64'hFFFF_FFFF_FFFF_FFFF);

    // R11: shared storage
    req(1, 1, 0, 0, 0, 0, 0, 0, 64'h0, 64'h0807_0605_0403_0201);
    step("R11 byte write");
    rd("R11 half read", 1, 0);
    expect_rd("R11 overlay", 64'h0007_0005_0003_0001);

    // R9: illegal requests
    req(1, 0, 2, 0, 0, 0, 0, 0, 64'hFF, 64'hFF);  step("R9 bad fmt");
    req(1, 0, 1, 8, 0, 0, 0, 0, 64'hFF, 64'h0);   step("R9 absd half");
    req(1, 0, 0, 9, 0, 0, 0, 0, 64'hFF, 64'h0);   step("R9 bad opcode");
    req(1, 0, 0, 0, 3, 0, 0, 0, 64'hFF, 64'h0);   step("R9 bad source");
    req(1, 3, 0, 0, 0, 0, 0, 3, 64'h0, 64'h0);    step("R9 bad slice");
    expect_rd("R9 rd kept", 64'h0007_0005_0003_0001);
    req(1, 1, 3, 0, 0, 0, 0, 0, 64'hFF, 64'hFF);  step("R9 bad fmt write");
    rd("R11 after errors", 1, 0);
    expect_rd("R9 file unchanged", 64'h0007_0005_0003_0001);

    // R10: idle
    req(0, 1, 0, 0, 0, 0, 0, 0, 64'hFFFF, 64'hFFFF);
    step("R10 idle");
    req(1, 0, 0, 1, 0, 0, 0, 0, 64'h5, 64'h5);
    step("R10 arith keeps rd");
    expect_rd("R10 rd kept", 64'h0007_0005_0003_0001);

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] f;
      f = ($urandom % 16 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
      req(($urandom % 8) != 0, 2'($urandom), f, 4'($urandom % 10),
          ($urandom % 12 == 0) ? 2'd3 : 2'($urandom % 3), 3'($urandom),
          16'($urandom), ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3),
          {$urandom, $urandom}, {$urandom, $urandom});
      step("R2 R3 R4 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule